// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O with Single-Line Set/Clear

This block gives a processor three 8-bit parallel ports, A, B and C, behind a small register window of four addresses. Port C is split into an upper and a lower nibble, and each nibble takes its direction on its own. Port C can therefore serve as one 8-bit port or as two 4-bit ports. Only basic unstrobed transfers are supported. Each port drives a pad-side output vector, an output-enable vector, and reads a pad-side input vector.

One write-only command address carries two kinds of word, and the top bit tells them apart. A word with the top bit high defines the port directions and zeroes every output latch. A word with the top bit low sets or clears one chosen line of port C and leaves the rest of the block unchanged. Writes are taken on the rising edge of the write strobe, sampled on the system clock. Reads need no clock: input ports show the live pins, and output ports show their latches.

Top module: `pio_triport`

## Requirements
- R1: While reset is high, and after it falls, every output enable is 0 (all ports inputs) and every output latch is 0.
- R2: A command-address write (address 2'b11) with bit 7 = 1 sets directions. Each of these bits makes its target an input when it is 1 and an output when it is 0: bit 4 for port A, bit 1 for port B, bit 3 for port C bits 7..4, bit 0 for port C bits 3..0. An output port drives all-ones on its enable bits. An input port drives zeros there.
- R3: Any direction-setting write clears the latches of ports A, B and C to 0.
- R4: A write to address 2'b00 (A), 2'b01 (B) or 2'b10 (C) loads that port's latch on the clock after the write strobe rises with chip select high. The latch holds after the strobe falls. A strobe with chip select low changes nothing. The latch loads even when the port is an input.
- R5: A command-address write with bit 7 = 0 is a set/clear command. Bits 3..1 pick the port C line and bit 0 is its new value. Bits 6..4 are ignored. No other port C line, no direction and no port A/B latch changes.
- R6: A set/clear command updates the port C latch even while that nibble is an input. The new value shows on the port C output vector while the nibble's enables stay 0.
- R7: Reading a port, or a port C nibble, configured as input returns the present pin values. Pin changes between two reads show up in the second read.
- R8: Reading a port configured as output returns its latch. A port C read mixes pins and latch per nibble.
- R9: A read of the command address returns 8'hFF and changes no state. With no read in progress, the read bus is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high, rising edge commits |
| addr | input | 2 | Register select: A, B, C, command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A latch out |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B latch out |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C latch out |
| pc_oe | output | 8 | Port C output enables |

## Verification
The direction words used are all-output, upper-C-only input, mixed A/B input with upper C output, lower-C-only input and all-input. Together they show that each direction bit reaches only its own port or nibble. Set/clear commands target the top line, the bottom line and a middle line. One of them carries ones in the ignored bits, and one targets a nibble that is an input. This tells a correct single-line update apart from wrong decoding of the index, the value or the ignored field. Reads taken before and after the pins change separate live pin reads from latched reads, and a split port C read checks that the nibbles are merged independently.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int SEL_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } port_sel_e;

  // 1 = input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_cfg_t;

  localparam dir_cfg_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
  localparam logic [7:0] CTRL_READ_VALUE = 8'hFF;

  function automatic dir_cfg_t mode_dirs(input logic [7:0] w);
    dir_cfg_t d;
    d.a_in  = w[4];
    d.b_in  = w[1];
    d.cu_in = w[3];
    d.cl_in = w[0];
    return d;
  endfunction

  function automatic logic [SEL_W-1:0] bsr_index(input logic [7:0] w);
    return w[SEL_W:1];
  endfunction

  function automatic logic bsr_value(input logic [7:0] w);
    return w[0];
  endfunction

  function automatic logic [PORT_W-1:0] bsr_apply(input logic [PORT_W-1:0] cur,
                                                  input logic [SEL_W-1:0] idx,
                                                  input logic v);
    logic [PORT_W-1:0] r;
    r = cur;
    r[idx] = v;
    return r;
  endfunction

  // in_mask bit = 1 selects the pin, 0 selects the latch
  function automatic logic [PORT_W-1:0] merge_read(input logic [PORT_W-1:0] pins,
                                                   input logic [PORT_W-1:0] latch,
                                                   input logic [PORT_W-1:0] in_mask);
    return (pins & in_mask) | (latch & ~in_mask);
  endfunction
endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic       cmd_top,
  output logic       wr_commit,
  output logic       c_load,
  output logic       mode_fire,
  output logic       bsr_fire
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b0;
    else     wr_q <= wr;
  end

  assign wr_commit = cs && wr && !wr_q;
  assign c_load    = wr_commit && (addr == SEL_C);
  assign mode_fire = wr_commit && (addr == SEL_CTRL) && cmd_top;
  assign bsr_fire  = wr_commit && (addr == SEL_CTRL) && !cmd_top;
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_fire,
  input  logic [7:0] wdata,
  output dir_cfg_t   dirs
);
  always_ff @(posedge clk) begin
    if (rst)            dirs <= DIR_RESET;
    else if (mode_fire) dirs <= mode_dirs(wdata);
  end
endmodule

// File: rtl/pio_latch.sv
module pio_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clear) q <= '0;
    else if (load)    q <= din;
  end
endmodule

// File: rtl/pio_portc.sv
module pio_portc
  import pio_pkg::*;
#(
  parameter int W  = PORT_W,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [W-1:0]  din,
  input  logic          bsr,
  input  logic [IW-1:0] bsr_idx,
  input  logic          bsr_val,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end else if (bsr) begin
      q <= bsr_apply(q, bsr_idx, bsr_val);
    end
  end
endmodule

// File: rtl/pio_triport.sv
module pio_triport
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  // Named internal events for the checker
  logic     wr_commit;
  logic     c_load;
  logic     mode_fire;
  logic     bsr_fire;
  dir_cfg_t dirs;

  logic [PORT_W-1:0] ab_q [2];
  logic [1:0]        ab_load;
  logic [PORT_W-1:0] c_q;
  logic [PORT_W-1:0] a_mask, b_mask, c_mask;

  pio_bus_if u_bus (
    .clk       (clk),
    .rst       (rst),
    .cs        (cs),
    .wr        (wr),
    .addr      (addr),
    .cmd_top   (wdata[7]),
    .wr_commit (wr_commit),
    .c_load    (c_load),
    .mode_fire (mode_fire),
    .bsr_fire  (bsr_fire)
  );

  pio_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_fire (mode_fire),
    .wdata     (wdata),
    .dirs      (dirs)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ab
    assign ab_load[g] = wr_commit && (addr == 2'(g));
    pio_latch #(.W(PORT_W)) u_lat (
      .clk   (clk),
      .rst   (rst),
      .clear (mode_fire),
      .load  (ab_load[g]),
      .din   (wdata),
      .q     (ab_q[g])
    );
  end

  pio_portc #(.W(PORT_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .clear   (mode_fire),
    .load    (c_load),
    .din     (wdata),
    .bsr     (bsr_fire),
    .bsr_idx (bsr_index(wdata)),
    .bsr_val (bsr_value(wdata)),
    .q       (c_q)
  );

  assign a_mask = {PORT_W{dirs.a_in}};
  assign b_mask = {PORT_W{dirs.b_in}};
  assign c_mask = {{HALF_W{dirs.cu_in}}, {HALF_W{dirs.cl_in}}};

  assign pa_out = ab_q[0];
  assign pb_out = ab_q[1];
  assign pc_out = c_q;
  assign pa_oe  = ~a_mask;
  assign pb_oe  = ~b_mask;
  assign pc_oe  = ~c_mask;

  always_comb begin
    rdata = 8'h00;
    if (cs && rd) begin
      unique case (addr)
        SEL_A:    rdata = merge_read(pa_in, ab_q[0], a_mask);
        SEL_B:    rdata = merge_read(pb_in, ab_q[1], b_mask);
        SEL_C:    rdata = merge_read(pc_in, c_q, c_mask);
        default:  rdata = CTRL_READ_VALUE;
      endcase
    end
  end
endmodule

// File: rtl/pio_triport_chk.sv
module pio_triport_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       rd,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe,
  input logic       wr_commit,
  input logic       mode_fire,
  input logic       bsr_fire
);
  // R5
  bsr_one_line_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_fire |=> $countones(pc_out ^ $past(pc_out)) <= 1);

  // R5
  bsr_target_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_fire |=> pc_out[$past(wdata[3:1])] == $past(wdata[0]));

  // R5
  bsr_keeps_rest_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_fire |=> $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)
                 && $stable(pa_out) && $stable(pb_out));

  // R3
  mode_clears_chk: assert property (@(posedge clk) disable iff (rst)
    mode_fire |=> (pa_out == 8'h00) && (pb_out == 8'h00) && (pc_out == 8'h00));

  // R2
  mode_dir_a_chk: assert property (@(posedge clk) disable iff (rst)
    mode_fire |=> pa_oe == {8{~$past(wdata[4])}});

  // R2
  mode_dir_cu_chk: assert property (@(posedge clk) disable iff (rst)
    mode_fire |=> pc_oe[7:4] == {4{~$past(wdata[3])}});

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_commit |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                   && $stable(pa_oe) && $stable(pc_oe));

  // R9
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == 2'b11) |-> rdata == 8'hFF);
endmodule

bind pio_triport pio_triport_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs        (cs),
  .rd        (rd),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .pa_out    (pa_out),
  .pa_oe     (pa_oe),
  .pb_out    (pb_out),
  .pb_oe     (pb_oe),
  .pc_out    (pc_out),
  .pc_oe     (pc_oe),
  .wr_commit (wr_commit),
  .mode_fire (mode_fire),
  .bsr_fire  (bsr_fire)
);

// File: tb/tb_pio_triport.sv
module tb_pio_triport;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pio_triport dut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // entry: {addr, data, exp pa_out, exp pb_out, exp pc_out, out flags {A,B,CU,CL}}
  localparam logic [37:0] VEC [NVEC] = '{
    {2'b11, 8'h80, 8'h00, 8'h00, 8'h00, 4'b1111}, // R2 all outputs
    {2'b00, 8'h5A, 8'h5A, 8'h00, 8'h00, 4'b1111}, // R4
    {2'b01, 8'hC3, 8'h5A, 8'hC3, 8'h00, 4'b1111}, // R4
    {2'b10, 8'h0F, 8'h5A, 8'hC3, 8'h0F, 4'b1111}, // R4
    {2'b11, 8'h0F, 8'h5A, 8'hC3, 8'h8F, 4'b1111}, // R5 set line 7
    {2'b11, 8'h70, 8'h5A, 8'hC3, 8'h8E, 4'b1111}, // R5 clear line 0, junk in 6..4
    {2'b11, 8'h09, 8'h5A, 8'hC3, 8'h9E, 4'b1111}, // R5 set line 4
    {2'b11, 8'h88, 8'h00, 8'h00, 8'h00, 4'b1101}, // R2 R3 upper C input
    {2'b11, 8'h0D, 8'h00, 8'h00, 8'h40, 4'b1101}, // R6 set line 6 in input nibble
    {2'b11, 8'h93, 8'h00, 8'h00, 8'h00, 4'b0010}, // R2 R3 mixed
    {2'b00, 8'hFF, 8'hFF, 8'h00, 8'h00, 4'b0010}, // R4 load while input
    {2'b11, 8'h9B, 8'h00, 8'h00, 8'h00, 4'b0000}  // R2 R3 all inputs
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] snap;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 oe in reset", {pa_oe, pb_oe, pc_oe}, 32'h0);
    check("R1 latches in reset", {pa_out, pb_out, pc_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after reset", {pa_oe, pb_oe, pc_oe}, 32'h0);
    check("R9 idle read bus", rdata, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [37:0] v;
      v = VEC[i];
      bus_write(v[37:36], v[35:28]);
      check($sformatf("R2/R3/R4/R5/R6 step %0d outs", i),
            {pa_out, pb_out, pc_out}, {8'h0, v[27:4]});
      check($sformatf("R2/R5/R6 step %0d oe", i),
            {pa_oe, pb_oe, pc_oe},
            {8'h0, {8{v[3]}}, {8{v[2]}}, {4{v[1]}}, {4{v[0]}}});
    end

    // R4 strobe with chip select low
    bus_write(2'b11, 8'h80);
    bus_write(2'b00, 8'h21);
    @(negedge clk);
    cs = 1'b0; addr = 2'b00; wdata = 8'hEE; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    check("R4 write with cs low ignored", pa_out, 8'h21);
    repeat (5) @(negedge clk);
    check("R4 latch holds after strobe", pa_out, 8'h21);

    // R7 live pin reads, all inputs
    bus_write(2'b11, 8'h9B);
    pa_in = 8'h3C;
    bus_read(2'b00, rv);
    check("R7 A pins read", rv, 8'h3C);
    pa_in = 8'hA5;
    bus_read(2'b00, rv);
    check("R7 A pins follow change", rv, 8'hA5);
    pb_in = 8'h17;
    bus_read(2'b01, rv);
    check("R7 B pins read", rv, 8'h17);

    // R8 lower C input, rest output
    bus_write(2'b11, 8'h81);
    bus_write(2'b10, 8'hB7);
    pc_in = 8'h29;
    bus_read(2'b10, rv);
    check("R8 split C read", rv, 8'hB9);
    bus_write(2'b01, 8'h66);
    pb_in = 8'h00;
    bus_read(2'b01, rv);
    check("R8 B output reads latch", rv, 8'h66);

    // R9 control read is constant and harmless
    snap = pc_out;
    bus_read(2'b11, rv);
    check("R9 ctrl read value", rv, 8'hFF);
    @(negedge clk);
    check("R9 no side effect", {pb_out, pc_out, pc_oe}, {8'h0, 8'h66, snap, 8'hF0});

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 reset clears latches", {pa_out, pb_out, pc_out}, 32'h0);
    check("R1 reset sets inputs", {pa_oe, pb_oe, pc_oe}, 32'h0);

    finish_run();
  end
endmodule